// File: doc/BRIEF.md
# Streaming Sink Adapter with Ready-Latency Skid and Symbol Reordering

This block terminates one valid/ready packet stream and hands its beats to internal logic through a read port. The port can be used two ways. A blocking read raises a stall flag and takes nothing while no beat is stored. A non-blocking read returns a success flag that is low when nothing is stored. Beats land in a small FIFO. Its depth is the ready latency plus one, plus an optional number of extra words. Because of this, every beat the source may still send after ready falls has a slot.

On the stream side, the source may send a beat in cycle t only when ready was high in cycle t minus the ready latency. The latency is a parameter from 0 to 8. The data bus is cut into symbols. A parameter says whether the first symbol travels in the low-order or the high-order bits. The read port always presents the first symbol in the lowest bits. Start-of-packet and end-of-packet flags travel with each beat. An optional empty count gives the number of unused symbols in the last beat of a packet, and it is expanded into a per-symbol keep mask. In the valid-less mode, every permitted cycle is taken as a good beat. Parameter sets that break the rules are refused at elaboration: a latency above 8, a symbol width that does not divide the data width, empty without packets or with a single symbol, and valid-less mode with a non-zero latency or buffer.

Top module: `stream_sink_adapter`

## Requirements
- R1: Out of reset the FIFO is empty: `inReady` is 1, and `rdOk` and `rdStall` are 0 while `rdReq` is 0.
- R2: `inReady` is 0 exactly when the stored beat count is at least DEPTH minus RDY_LAT, where DEPTH = RDY_LAT + 1 + BUF_WORDS.
- R3: With valid in use, a beat is stored in cycle t only if `inValid` is 1 and `inReady` was 1 in cycle t minus RDY_LAT. A beat offered outside that window is discarded.
- R4: Stored beats are read out in arrival order, none is lost, and the FIFO never holds more than DEPTH beats.
- R5: A beat stored at a clock edge is readable from the following cycle. A read in the cycle the beat is offered does not return it.
- R6: A non-blocking read (`rdReq`=1, `rdBlock`=0) gives `rdOk`=1 and removes the head beat when a beat is stored. Otherwise it gives `rdOk`=0 and removes nothing.
- R7: A blocking read with nothing stored gives `rdStall`=1 and `rdOk`=0, and nothing is removed.
- R8: With HI_FIRST=0, bus symbol k is bits [SYM_W*k +: SYM_W]. With HI_FIRST=1, bus symbol k is bits [SYM_W*(NSYM-1-k) +: SYM_W]. `rdData` always carries symbol k at [SYM_W*k +: SYM_W].
- R9: On an end-of-packet beat, `rdKeep` bit k is 1 exactly for k < NSYM minus `rdEmpty`. On other beats every bit is 1. The empty symbols are thus the last ones in stream order, whichever bus order is set.
- R10: `rdSop`, `rdEop` and `rdEmpty` return the sideband values that arrived with the same beat.
- R11: With USE_VALID=0, every cycle in which the latency rule permits a beat stores one, whatever `inValid` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Source beat valid (ignored when USE_VALID=0) |
| inReady | output | 1 | Sink can take beats RDY_LAT cycles later |
| inData | input | DATA_W | Beat data in bus symbol order |
| inSop | input | 1 | Start of packet |
| inEop | input | 1 | End of packet |
| inEmpty | input | EW | Unused symbols in the last beat |
| rdReq | input | 1 | Read attempt from internal logic |
| rdBlock | input | 1 | 1 = blocking read, 0 = non-blocking |
| rdOk | output | 1 | Read returned a beat this cycle |
| rdStall | output | 1 | Blocking read is waiting |
| rdData | output | DATA_W | Head beat, first symbol in low bits |
| rdSop | output | 1 | Head beat start of packet |
| rdEop | output | 1 | Head beat end of packet |
| rdEmpty | output | EW | Head beat empty count |
| rdKeep | output | NSYM | Valid symbol mask, bit k = symbol k |

## Verification
A store from the stream and a removal by a read can land on the same edge. This matters most when the FIFO is one beat from full or holds exactly one beat: the count must then stay put, ready must not flicker, and the head must advance to the new beat. The bench provokes this with long random runs where `inValid` and `rdReq` are both high most of the time, across three configurations (latency 2 with a buffer, latency 0 with reversed symbol order, and valid-less). A queue model checks ready, the read flags and the head beat every cycle.

// File: rtl/stream_sink_pkg.sv
`timescale 1ns/1ps
package stream_sink_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } sink_strobe_t;
endpackage

// File: rtl/sink_ctrl.sv
`timescale 1ns/1ps
module sink_ctrl
  import stream_sink_pkg::*;
#(
  parameter int DEPTH     = 5,
  parameter int RDY_LAT   = 2,
  parameter bit USE_VALID = 1'b1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  input  logic         rdReq,
  input  logic         rdBlock,
  output logic         rdOk,
  output logic         rdStall,
  output sink_strobe_t strb
);
  logic [CW-1:0] count;
  logic allowed;
  logic vldEff;
  logic nonEmpty;

  // leave room for every beat still in flight
  assign inReady = int'(count) < (DEPTH - RDY_LAT);

  generate
    if (RDY_LAT == 0) begin : g_noLat
      assign allowed = inReady;
    end else begin : g_lat
      logic [RDY_LAT-1:0] hist;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hist <= '0;
        else       hist <= (hist << 1) | RDY_LAT'(inReady);
      end
      assign allowed = hist[RDY_LAT-1];
    end
  endgenerate

  assign vldEff   = USE_VALID ? inValid : 1'b1;
  assign nonEmpty = count != '0;
  assign rdOk     = rdReq && nonEmpty;
  assign rdStall  = rdReq && rdBlock && !nonEmpty;
  assign strb.push = vldEff && allowed;
  assign strb.pop  = rdOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else       count <= count + CW'(strb.push) - CW'(strb.pop);
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (int'(count) < DEPTH || strb.pop));
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> count != '0);
  a_r5_push_visible: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> count != '0);
  a_r7_stall_no_pop: assert property (@(posedge clk) disable iff (!rstN)
    rdStall |-> !strb.pop);
endmodule

// File: rtl/sink_dpath.sv
`timescale 1ns/1ps
module sink_dpath
  import stream_sink_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SYM_W     = 8,
  parameter int DEPTH     = 5,
  parameter bit HI_FIRST  = 1'b0,
  parameter bit USE_PKT   = 1'b1,
  parameter bit USE_EMPTY = 1'b1,
  localparam int NSYM = DATA_W / SYM_W,
  localparam int EW   = (NSYM > 1) ? $clog2(NSYM) : 1,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sink_strobe_t      strb,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [EW-1:0]     inEmpty,
  output logic [DATA_W-1:0] rdData,
  output logic              rdSop,
  output logic              rdEop,
  output logic [EW-1:0]     rdEmpty,
  output logic [NSYM-1:0]   rdKeep
);
  logic [DATA_W-1:0] normData;
  logic [DATA_W-1:0] memData [DEPTH];
  logic              memSop  [DEPTH];
  logic              memEop  [DEPTH];
  logic [EW-1:0]     memEmpty[DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;

  // first symbol always lands in the low bits
  generate
    for (genvar k = 0; k < NSYM; k++) begin : g_sym
      localparam int SRC = HI_FIRST ? (NSYM - 1 - k) : k;
      assign normData[k*SYM_W +: SYM_W] = inData[SRC*SYM_W +: SYM_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.push) begin
      memData[wrPtr]  <= normData;
      memSop[wrPtr]   <= USE_PKT ? inSop : 1'b0;
      memEop[wrPtr]   <= USE_PKT ? inEop : 1'b0;
      memEmpty[wrPtr] <= USE_EMPTY ? inEmpty : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  end

  assign rdData  = memData[rdPtr];
  assign rdSop   = memSop[rdPtr];
  assign rdEop   = memEop[rdPtr];
  assign rdEmpty = memEmpty[rdPtr];

  generate
    for (genvar k = 0; k < NSYM; k++) begin : g_keep
      assign rdKeep[k] = !rdEop || (k < NSYM - int'(rdEmpty));
    end
  endgenerate

  a_r9_keep_prefix: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> (rdKeep & (rdKeep + 1'b1)) == '0);
  a_r9_keep_full_mid: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !rdEop) |-> &rdKeep);
endmodule

// File: rtl/stream_sink_adapter.sv
`timescale 1ns/1ps
module stream_sink_adapter
  import stream_sink_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SYM_W     = 8,
  parameter int RDY_LAT   = 2,
  parameter int BUF_WORDS = 2,
  parameter bit HI_FIRST  = 1'b0,
  parameter bit USE_PKT   = 1'b1,
  parameter bit USE_EMPTY = 1'b1,
  parameter bit USE_VALID = 1'b1,
  localparam int NSYM  = DATA_W / SYM_W,
  localparam int EW    = (NSYM > 1) ? $clog2(NSYM) : 1,
  localparam int DEPTH = RDY_LAT + 1 + BUF_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [EW-1:0]     inEmpty,
  input  logic              rdReq,
  input  logic              rdBlock,
  output logic              rdOk,
  output logic              rdStall,
  output logic [DATA_W-1:0] rdData,
  output logic              rdSop,
  output logic              rdEop,
  output logic [EW-1:0]     rdEmpty,
  output logic [NSYM-1:0]   rdKeep
);
  generate
    if (RDY_LAT < 0 || RDY_LAT > 8) begin : g_badLat
      $error("ready latency must lie in 0..8");
    end
    if (DATA_W % SYM_W != 0) begin : g_badSym
      $error("symbol width must divide data width");
    end
    if (USE_EMPTY && (!USE_PKT || NSYM < 2)) begin : g_badEmpty
      $error("empty needs packet mode and more than one symbol");
    end
    if (!USE_VALID && (RDY_LAT != 0 || BUF_WORDS != 0)) begin : g_badNoValid
      $error("valid-less mode needs zero latency and zero buffer");
    end
  endgenerate

  sink_strobe_t strb;

  sink_ctrl #(.DEPTH(DEPTH), .RDY_LAT(RDY_LAT), .USE_VALID(USE_VALID)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .rdReq(rdReq), .rdBlock(rdBlock), .rdOk(rdOk), .rdStall(rdStall), .strb(strb)
  );

  sink_dpath #(.DATA_W(DATA_W), .SYM_W(SYM_W), .DEPTH(DEPTH), .HI_FIRST(HI_FIRST),
               .USE_PKT(USE_PKT), .USE_EMPTY(USE_EMPTY)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .inSop(inSop),
    .inEop(inEop), .inEmpty(inEmpty), .rdData(rdData), .rdSop(rdSop),
    .rdEop(rdEop), .rdEmpty(rdEmpty), .rdKeep(rdKeep)
  );
endmodule

// File: tb/stream_sink_adapter_bench.sv
`timescale 1ns/1ps
module sink_ref #(
  parameter string NAME  = "A",
  parameter int    L     = 2,
  parameter int    BUF   = 2,
  parameter bit    HI    = 1'b0,
  parameter bit    NOVLD = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        vld,
  input  logic [31:0] data,
  input  logic        sop,
  input  logic        eop,
  input  logic [1:0]  emp,
  input  logic        rdReq,
  input  logic        rdBlock,
  input  logic        dReady,
  input  logic        dOk,
  input  logic        dStall,
  input  logic [31:0] dData,
  input  logic        dSop,
  input  logic        dEop,
  input  logic [1:0]  dEmp,
  input  logic [3:0]  dKeep,
  output int          checks,
  output int          errs
);
  typedef struct { logic [31:0] d; bit s; bit e; int m; } beat_t;
  beat_t q[$];
  bit    rlog[$];
  localparam int DEP = L + 1 + BUF;

  initial begin checks = 0; errs = 0; end

  function automatic logic [31:0] norm(logic [31:0] x);
    logic [31:0] n;
    for (int k = 0; k < 4; k++) begin
      int src = HI ? 3 - k : k;
      n[k*8 +: 8] = x[src*8 +: 8];
    end
    return n;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s %s actual=%0h expected=%0h", NAME, tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      q = {};
      rlog = {};
    end else begin
      bit rdyNow, allow, acc, pop;
      beat_t b;
      rdyNow = (DEP - q.size()) > L;
      if (L == 0) allow = rdyNow;
      else        allow = (rlog.size() >= L) ? rlog[L-1] : 1'b0;
      acc = (NOVLD || vld) && allow;
      pop = rdReq && q.size() > 0;
      if (pop) void'(q.pop_front());
      if (acc) begin
        b.d = norm(data); b.s = sop; b.e = eop; b.m = int'(emp);
        q.push_back(b);
      end
      rlog.push_front(rdyNow);
      if (rlog.size() > 9) void'(rlog.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic [3:0] keep;
      chk("R2 R3", "inReady", 64'(dReady), 64'((DEP - q.size()) > L));
      chk("R5 R6", "rdOk", 64'(dOk), 64'(rdReq && q.size() > 0));
      chk("R7", "rdStall", 64'(dStall), 64'(rdReq && rdBlock && q.size() == 0));
      if (q.size() > 0) begin
        chk("R4 R8 R11", "rdData", 64'(dData), 64'(q[0].d));
        chk("R10", "rdSop", 64'(dSop), 64'(q[0].s));
        chk("R10", "rdEop", 64'(dEop), 64'(q[0].e));
        chk("R10", "rdEmpty", 64'(dEmp), 64'(q[0].m));
        for (int k = 0; k < 4; k++) keep[k] = !q[0].e || (k < 4 - q[0].m);
        chk("R9", "rdKeep", 64'(dKeep), 64'(keep));
      end
    end
  end
endmodule

module stream_sink_adapter_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vld = 1'b0, sop = 1'b0, eop = 1'b0, rdReq = 1'b0, rdBlock = 1'b0;
  logic [31:0] data = '0;
  logic [1:0]  emp = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  logic rdyA, okA, stA, sopA, eopA; logic [31:0] datA; logic [1:0] empA; logic [3:0] keepA;
  logic rdyB, okB, stB, sopB, eopB; logic [31:0] datB; logic [1:0] empB; logic [3:0] keepB;
  logic rdyC, okC, stC, sopC, eopC; logic [31:0] datC; logic [1:0] empC; logic [3:0] keepC;
  int cA, eA, cB, eB, cC, eC;

  stream_sink_adapter #(.RDY_LAT(2), .BUF_WORDS(2), .HI_FIRST(1'b0)) u_stream_sink_adapter (
    .clk(clk), .rstN(rstN), .inValid(vld), .inReady(rdyA), .inData(data), .inSop(sop),
    .inEop(eop), .inEmpty(emp), .rdReq(rdReq), .rdBlock(rdBlock), .rdOk(okA),
    .rdStall(stA), .rdData(datA), .rdSop(sopA), .rdEop(eopA), .rdEmpty(empA), .rdKeep(keepA));
  stream_sink_adapter #(.RDY_LAT(0), .BUF_WORDS(1), .HI_FIRST(1'b1)) u_stream_sink_adapter_hi (
    .clk(clk), .rstN(rstN), .inValid(vld), .inReady(rdyB), .inData(data), .inSop(sop),
    .inEop(eop), .inEmpty(emp), .rdReq(rdReq), .rdBlock(rdBlock), .rdOk(okB),
    .rdStall(stB), .rdData(datB), .rdSop(sopB), .rdEop(eopB), .rdEmpty(empB), .rdKeep(keepB));
  stream_sink_adapter #(.RDY_LAT(0), .BUF_WORDS(0), .USE_VALID(1'b0)) u_stream_sink_adapter_nv (
    .clk(clk), .rstN(rstN), .inValid(vld), .inReady(rdyC), .inData(data), .inSop(sop),
    .inEop(eop), .inEmpty(emp), .rdReq(rdReq), .rdBlock(rdBlock), .rdOk(okC),
    .rdStall(stC), .rdData(datC), .rdSop(sopC), .rdEop(eopC), .rdEmpty(empC), .rdKeep(keepC));

  sink_ref #(.NAME("lat2"), .L(2), .BUF(2), .HI(1'b0), .NOVLD(1'b0)) m_a (
    .clk(clk), .rstN(rstN), .vld(vld), .data(data), .sop(sop), .eop(eop), .emp(emp),
    .rdReq(rdReq), .rdBlock(rdBlock), .dReady(rdyA), .dOk(okA), .dStall(stA), .dData(datA),
    .dSop(sopA), .dEop(eopA), .dEmp(empA), .dKeep(keepA), .checks(cA), .errs(eA));
  sink_ref #(.NAME("hifirst"), .L(0), .BUF(1), .HI(1'b1), .NOVLD(1'b0)) m_b (
    .clk(clk), .rstN(rstN), .vld(vld), .data(data), .sop(sop), .eop(eop), .emp(emp),
    .rdReq(rdReq), .rdBlock(rdBlock), .dReady(rdyB), .dOk(okB), .dStall(stB), .dData(datB),
    .dSop(sopB), .dEop(eopB), .dEmp(empB), .dKeep(keepB), .checks(cB), .errs(eB));
  sink_ref #(.NAME("novalid"), .L(0), .BUF(0), .HI(1'b0), .NOVLD(1'b1)) m_c (
    .clk(clk), .rstN(rstN), .vld(vld), .data(data), .sop(sop), .eop(eop), .emp(emp),
    .rdReq(rdReq), .rdBlock(rdBlock), .dReady(rdyC), .dOk(okC), .dStall(stC), .dData(datC),
    .dSop(sopC), .dEop(eopC), .dEmp(empC), .dKeep(keepC), .checks(cC), .errs(eC));

  task automatic own(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R1 %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic drive(bit v, bit rq, bit bl);
    @(posedge clk); #1;
    vld = v; rdReq = rq; rdBlock = bl;
    data = $urandom; sop = $urandom_range(0, 1); eop = $urandom_range(0, 1);
    emp = 2'($urandom_range(0, 3));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      checks += cA + cB + cC;
      errors += eA + eB + eC;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state of all three configurations
    own("inReady lat2", rdyA, 1'b1); own("inReady hifirst", rdyB, 1'b1);
    own("inReady novalid", rdyC, 1'b1);
    own("rdOk lat2", okA, 1'b0); own("rdStall lat2", stA, 1'b0);
    own("rdOk hifirst", okB, 1'b0);
    // fill with no reads: ready drops, late beats land in the skid (R2 R3 R4)
    repeat (14) drive(1'b1, 1'b0, 1'b0);
    // drain with non-blocking reads until they fail (R6)
    repeat (10) drive(1'b0, 1'b1, 1'b0);
    // blocking reads on an empty FIFO (R7)
    repeat (4) drive(1'b0, 1'b1, 1'b1);
    // offer and read in the same cycle on an empty FIFO (R5)
    repeat (4) drive(1'b1, 1'b1, 1'b0);
    // random mix: stores and removals on the same edge
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 7, $urandom_range(0, 1));
    // full-rate streaming
    repeat (300) drive(1'b1, 1'b1, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule